// File: doc/BRIEF.md
# Serial Register-Write Receiver with Chain Forwarding

This block takes register writes from a serial link. Each write is a 32-bit word sent MSB first on a data input. An active-low frame-sync input marks when the word starts. All logic runs on one clock, and each rising edge of `clk` stands for one falling edge of the serial clock, which is the sampling edge. When the frame-sync is seen low while the receiver is idle, a frame opens. The following edges capture one data bit each. Once a full word is in, it is split into an address half and a data half, and a one-cycle write strobe is raised.

The time the frame-sync stays low selects whether the frame holds one word or several. Several words are used when devices are chained. Suppose the frame-sync is still low on the edge that captures the 32nd bit. The receiver then keeps the frame open for one more word and switches its serial output into forwarding. While forwarding, each bit leaves the serial output 32 edges after it came in, so the next device in the chain receives the earlier words. The frame closes at the first word boundary at which the frame-sync has been seen high. The local device then commits the last 32 bits it shifted in.

Top module: `serialWriteRx`

## Requirements
- R1: While `rstN` is low, and on the first sample after it is released, `wrStrobe`, `passThru`, `serDataOut`, `wrAddr` and `wrData` are all 0.
- R2: When the receiver is idle and `frameSyncN` is sampled low on an edge, a frame opens. The next edge captures the first bit. Bits arrive MSB first. Of the committed word, bits 31..16 go to `wrAddr` and bits 15..0 go to `wrData`.
- R3: `wrStrobe` is high for exactly one cycle, in the cycle after the edge that captures the last bit of a frame. `wrAddr` and `wrData` change only together with a strobe.
- R4: If `frameSyncN` goes high again within 1 to 32 cycles after the opening edge, the frame holds exactly one word. A 1-cycle pulse counts, and so does a 32-cycle low period.
- R5: A new high-to-low change of `frameSyncN` inside an open frame is ignored. It neither restarts the frame nor lengthens it.
- R6: If `frameSyncN` is still low on the edge that captures bit 32k (counting from 1), `passThru` goes high after that edge. It stays high until the frame closes. While it is high, `serDataOut` carries the input bit that was captured 32 edges earlier.
- R7: If `frameSyncN` stays low for L cycles, with 32(n-1) < L <= 32n, the frame lasts 32n bits. Only the last 32 bits are committed, and exactly one strobe is issued.
- R8: Whenever `passThru` is low, `serDataOut` is 0. `passThru` is low in the cycle that carries the strobe.
- R9: A new frame can open on the edge right after the closing edge of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one rising edge per serial-clock falling edge |
| rstN | input | 1 | Synchronous active-low reset |
| frameSyncN | input | 1 | Active-low frame sync |
| serDataIn | input | 1 | Serial write data, MSB first |
| serDataOut | output | 1 | Forwarded data for the next chained device |
| passThru | output | 1 | High while bits are being forwarded downstream |
| wrStrobe | output | 1 | One-cycle register write strobe |
| wrAddr | output | 16 | Address half of the committed word |
| wrData | output | 16 | Data half of the committed word |

## Verification
The bench probes how the low time of the frame-sync maps onto the frame length. A 1-cycle pulse must still bring in a full word. A low time of exactly 32 cycles must not start forwarding, while 33 must, and 96 must give three words and not four. A design that counts the low time exactly, or that reads the sync one edge late, would either cut words short or grow an extra word. A second low pulse inside a frame checks that the receiver does not restart, which would show up as a missing or misaligned strobe. The forwarded stream is compared bit by bit against the input delayed by 32, so an off-by-one in the forwarding tap shifts every downstream bit. Back-to-back frames check that the closing edge does not swallow the next opening edge.

// File: rtl/wrRxPkg.sv
package wrRxPkg;

  // Strobes from the frame controller to the shift datapath
  typedef struct packed {
    logic shiftEn;   // capture serDataIn this edge
    logic commit;    // last bit of frame: latch word and strobe
  } rxCtrl_t;

endpackage

// File: rtl/wrRxCtrl.sv
module wrRxCtrl
  import wrRxPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameSyncN,
  output rxCtrl_t ctrl,
  output logic    passThru
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             inFrame;
  logic [CNT_W-1:0] bitCnt;
  logic             syncSeenHigh;
  logic             startFrame;
  logic             wordDone;
  logic             endNow;
  logic             passRaise;

  always_comb begin
    startFrame = !inFrame && !frameSyncN;
    wordDone   = inFrame && (bitCnt == LAST_BIT);
    endNow     = wordDone && (syncSeenHigh || frameSyncN);
    passRaise  = wordDone && !(syncSeenHigh || frameSyncN);
    ctrl.shiftEn = inFrame;
    ctrl.commit  = endNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      bitCnt       <= '0;
      syncSeenHigh <= 1'b0;
      passThru     <= 1'b0;
    end else if (startFrame) begin
      inFrame      <= 1'b1;
      bitCnt       <= '0;
      syncSeenHigh <= 1'b0;
      passThru     <= 1'b0;
    end else if (inFrame) begin
      bitCnt       <= wordDone ? '0 : bitCnt + 1'b1;
      syncSeenHigh <= syncSeenHigh || frameSyncN;
      if (endNow) begin
        inFrame  <= 1'b0;
        passThru <= 1'b0;
      end else if (passRaise) begin
        passThru <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wrRxDatapath.sv
module wrRxDatapath
  import wrRxPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxCtrl_t                  ctrl,
  input  logic                     passThru,
  input  logic                     serDataIn,
  output logic                     serDataOut,
  output logic                     wrStrobe,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [WORD_W-ADDR_W-1:0] wrData
);

  localparam int DATA_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord   = {shiftReg[WORD_W-2:0], serDataIn};
  assign serDataOut = passThru & shiftReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= ctrl.commit;
      if (ctrl.shiftEn) shiftReg <= nextWord;
      if (ctrl.commit) begin
        wrAddr <= nextWord[WORD_W-1 -: ADDR_W];
        wrData <= nextWord[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/serialWriteRx.sv
module serialWriteRx
  import wrRxPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameSyncN,
  input  logic                     serDataIn,
  output logic                     serDataOut,
  output logic                     passThru,
  output logic                     wrStrobe,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [WORD_W-ADDR_W-1:0] wrData
);

  rxCtrl_t ctrl;

  wrRxCtrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameSyncN (frameSyncN),
    .ctrl       (ctrl),
    .passThru   (passThru)
  );

  wrRxDatapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .passThru   (passThru),
    .serDataIn  (serDataIn),
    .serDataOut (serDataOut),
    .wrStrobe   (wrStrobe),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );

endmodule

// File: rtl/wrRxChecker.sv
module wrRxChecker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     frameSyncN,
  input logic                     serDataOut,
  input logic                     passThru,
  input logic                     wrStrobe,
  input logic [ADDR_W-1:0]        wrAddr,
  input logic [WORD_W-ADDR_W-1:0] wrData
);

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!wrStrobe && !passThru && !serDataOut));

  // R3: strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R3: fields move only together with a strobe
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> ($stable(wrAddr) && $stable(wrData)));

  // R8: no forwarding in the strobe cycle
  a_r8_no_pass_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !passThru);

  // R6: forwarding only starts while the sync was still low
  a_r6_pass_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passThru) |-> !$past(frameSyncN));

endmodule

bind serialWriteRx wrRxChecker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .frameSyncN (frameSyncN),
  .serDataOut (serDataOut),
  .passThru   (passThru),
  .wrStrobe   (wrStrobe),
  .wrAddr     (wrAddr),
  .wrData     (wrData)
);

// File: tb/serialWriteRx_tb_top.sv
module serialWriteRx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSyncN = 1'b1;
  logic        serDataIn = 1'b0;
  logic        serDataOut;
  logic        passThru;
  logic        wrStrobe;
  logic [15:0] wrAddr;
  logic [15:0] wrData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialWriteRx dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameSyncN (frameSyncN),
    .serDataIn  (serDataIn),
    .serDataOut (serDataOut),
    .passThru   (passThru),
    .wrStrobe   (wrStrobe),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic streamBit(input logic [31:0] w0, input logic [31:0] w1,
                                     input logic [31:0] w2, input int idx);
    logic [31:0] w;
    w = (idx < 32) ? w0 : (idx < 64) ? w1 : w2;
    return w[31 - (idx % 32)];
  endfunction

  // Drives one frame edge by edge and checks every cycle.
  // Edge 0 opens the frame; edges 1..32*nWords capture bits.
  task automatic runFrame(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input int nWords,
                          input int lowLen, input int glitchAt,
                          input bit followOn, input string req);
    logic [31:0] lastWord;
    int lastEdge;
    lastEdge = 32 * nWords;
    lastWord = (nWords == 1) ? w0 : (nWords == 2) ? w1 : w2;
    for (int e = 0; e <= lastEdge; e++) begin
      @(negedge clk);
      frameSyncN = (e < lowLen || e == glitchAt) ? 1'b0 : 1'b1;
      serDataIn  = (e >= 1) ? streamBit(w0, w1, w2, e - 1) : 1'b0;
      @(posedge clk);
      #2;
      begin
        bit expPass;
        logic expSdo;
        expPass = (e >= 32) && (e < lastEdge);
        expSdo  = expPass ? streamBit(w0, w1, w2, e - 32) : 1'b0;
        checkEq((e == lastEdge) ? {req, " R3"} : req, "wrStrobe",
                32'(wrStrobe), 32'(e == lastEdge));
        checkEq(expPass ? "R6" : "R8", "passThru", 32'(passThru), 32'(expPass));
        checkEq(expPass ? "R6" : "R8", "serDataOut", 32'(serDataOut), 32'(expSdo));
        if (e == lastEdge) begin
          checkEq({req, " R2"}, "wrAddr", 32'(wrAddr), 32'(lastWord[31:16]));
          checkEq({req, " R2"}, "wrData", 32'(wrData), 32'(lastWord[15:0]));
        end
      end
    end
    if (!followOn) begin
      @(negedge clk);
      frameSyncN = 1'b1;
      serDataIn  = 1'b0;
      @(posedge clk);
      #2;
      checkEq("R3", "wrStrobe after frame", 32'(wrStrobe), 32'd0);
      checkEq("R8", "passThru after frame", 32'(passThru), 32'd0);
      checkEq("R3", "wrAddr hold", 32'(wrAddr), 32'(lastWord[31:16]));
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    checkEq("R1", "wrStrobe in reset", 32'(wrStrobe), 32'd0);
    checkEq("R1", "passThru in reset", 32'(passThru), 32'd0);
    checkEq("R1", "serDataOut in reset", 32'(serDataOut), 32'd0);
    checkEq("R1", "wrAddr in reset", 32'(wrAddr), 32'd0);
    checkEq("R1", "wrData in reset", 32'(wrData), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    checkEq("R1", "wrStrobe after release", 32'(wrStrobe), 32'd0);
  endtask

  task automatic testShortPulse();   // R4, one-cycle sync pulse
    runFrame(32'hA5C3_1234, 32'h0, 32'h0, 1, 1, -1, 1'b0, "R4");
  endtask

  task automatic testFullLowWord();  // R4, low for exactly 32 cycles
    runFrame(32'h8001_7FFE, 32'h0, 32'h0, 1, 32, -1, 1'b0, "R4");
  endtask

  task automatic testGlitch();       // R5, second sync fall mid frame
    runFrame(32'h3C3C_F00F, 32'h0, 32'h0, 1, 3, 10, 1'b0, "R5");
  endtask

  task automatic testChainTwo();     // R6 R7, low for 33 cycles
    runFrame(32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0, 2, 33, -1, 1'b0, "R7");
  endtask

  task automatic testChainThree();   // R7, low for 96 cycles
    runFrame(32'h0F1E_2D3C, 32'hFFFF_0000, 32'h6B6B_9494, 3, 96, -1, 1'b0, "R7");
  endtask

  task automatic testBackToBack();   // R9
    runFrame(32'h1111_2222, 32'h0, 32'h0, 1, 2, -1, 1'b1, "R9");
    runFrame(32'hC0DE_5EED, 32'h0, 32'h0, 1, 1, -1, 1'b0, "R9");
  endtask

  initial begin
    testReset();
    testShortPulse();
    testFullLowWord();
    testGlitch();
    testChainTwo();
    testChainThree();
    testBackToBack();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule